// File: doc/BRIEF.md
# Parallel Port FIFO Engine

This block moves bytes between a host register bus and the eight data lines of a parallel port through one 16-byte FIFO. A 3-bit mode field selects how the FIFO is used:
- compatibility mode sends host bytes to a printer-style peripheral with a strobe/busy handshake;
- ECP data mode runs in either direction. It sends host bytes out with a clock/acknowledge handshake, or captures peripheral bytes for the host to read;
- test mode lets the host write and read the FIFO directly, and shows the head byte on the data lines without any handshake;
- configuration mode exposes two fixed identification registers.

The host uses single-cycle read and write strobes with a 2-bit address. A DMA request output tells an external controller when the FIFO can take or give a byte. A DMA acknowledge input turns the current strobe into a FIFO access whatever the address. The same port pins serve both handshakes. `stb_n` is the strobe in compatibility mode and the host clock in ECP forward. `busy` is the busy line or the peripheral acknowledge. `pclk_n` is the peripheral clock and `hack` is the host acknowledge.

Top module: `ecp_fifo_port`

## Requirements
- R1: After reset the mode field is 000, the direction bit is 0 and the FIFO is empty. `stb_n` is 1 and `hack` is 0. `pd_oe` and `dma_req` are 0. The control register at address 2 reads 0x01.
- R2: The FIFO holds 16 bytes and returns them in write order. A write to a full FIFO is dropped. A read of an empty FIFO removes nothing.
- R3: In mode 110 the host writes and reads the FIFO at address 0. `pd_oe` is 1 and `pd_out` shows the head byte. `stb_n` stays 1 and `hack` stays 0.
- R4: In mode 111 a read of address 0 returns 0x10. Writes to address 0 in that mode leave the FIFO unchanged.
- R5: In mode 111 a read of address 1 returns 0 in bit 7, the level of `irq_in` in bit 6, and 0 in bits 5..0.
- R6: In mode 010 the engine takes the head byte, waits until `busy` is 0, and drives `stb_n` low for at least 2 clocks. While `stb_n` is low, `pd_out` holds the byte. The engine then waits for `busy` to be 0 before it starts the next byte.
- R7: In mode 011 with direction 0 the engine drives the byte and pulls `stb_n` low. It keeps `stb_n` low until `busy` is 1, then raises it. It waits for `busy` to be 0 before the next byte.
- R8: In mode 011 with direction 1, `pd_oe` is 0. When `pclk_n` is low and the FIFO is not full, the engine stores `pd_in` and raises `hack`. It lowers `hack` once `pclk_n` is high again.
- R9: `dma_req` is 1 in modes 010 and 011/direction 0 while the FIFO is not full. It is 1 in mode 011/direction 1 while the FIFO is not empty. It is 0 in every other mode.
- R10: A control-register write that changes the mode or the direction empties the FIFO and returns the handshake to idle. After such a write `stb_n` is 1 and `hack` is 0.
- R11: The control register at address 2 has these fields: bits 7..5 hold the mode, bit 4 the direction, bit 1 full and bit 0 empty. Bits 3..2 read 0. A write to address 2 loads the mode from bits 7..5 and the direction from bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hs_wr | input | 1 | Host write strobe, one cycle per byte |
| hs_rd | input | 1 | Host read strobe, one cycle per byte |
| hs_addr | input | 2 | Register address |
| hs_wdata | input | 8 | Host write data |
| hs_rdata | output | 8 | Host read data, valid during the read strobe |
| dma_req | output | 1 | FIFO ready for a DMA transfer |
| dma_ack | input | 1 | Current strobe is a DMA FIFO access |
| irq_in | input | 1 | Interrupt line level, reflected in configuration register B |
| pd_out | output | 8 | Port data driven out |
| pd_in | input | 8 | Port data from the peripheral |
| pd_oe | output | 1 | Port data output enable |
| stb_n | output | 1 | Strobe or host clock, active low |
| busy | input | 1 | Busy or peripheral acknowledge |
| pclk_n | input | 1 | Peripheral clock, active low |
| hack | output | 1 | Host acknowledge |

## Verification
A corrupted read or write pointer shows up on the first read of the next byte as a wrong value or a wrong order. In the output modes it shows as a wrong `pd_out` byte at the next strobe. A count that drifts makes the full or empty bit of the control register wrong, and flips `dma_req`, within one access. A handshake state that skips a wait shows at once as a strobe that is too short, or as `stb_n` or `hack` moving before the peripheral line they depend on.

// File: rtl/ecp_fifo_port.sv
module ecp_fifo_port #(
  parameter int DW       = 8,
  parameter int DEPTH    = 16,
  parameter int STB_CLKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_wr,
  input  logic          hs_rd,
  input  logic [1:0]    hs_addr,
  input  logic [DW-1:0] hs_wdata,
  output logic [DW-1:0] hs_rdata,
  output logic          dma_req,
  input  logic          dma_ack,
  input  logic          irq_in,
  output logic [DW-1:0] pd_out,
  input  logic [DW-1:0] pd_in,
  output logic          pd_oe,
  output logic          stb_n,
  input  logic          busy,
  input  logic          pclk_n,
  output logic          hack
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(STB_CLKS + 1);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [2:0] M_COMPAT = 3'b010, M_ECP = 3'b011, M_TEST = 3'b110, M_CFG = 3'b111;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STB, S_HOLD, S_EACK, S_EREL, S_RACK} st_t;
  st_t st;

  logic [2:0]    mode;
  logic          dir;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic [DW-1:0] out_q;
  logic [SW-1:0] scnt;

  wire full  = cnt == FULL_CNT;
  wire empty = cnt == '0;
  wire [DW-1:0] head = mem[rptr];

  wire fwd  = (mode == M_COMPAT) || (mode == M_ECP && !dir);
  wire rev  = (mode == M_ECP) && dir;
  wire test = mode == M_TEST;

  wire ecr_wr   = hs_wr && !dma_ack && hs_addr == 2'd2;
  wire mode_chg = ecr_wr && {hs_wdata[7:5], hs_wdata[4]} != {mode, dir};
  wire fifo_acc = dma_ack || hs_addr == 2'd0;

  wire host_push = hs_wr && fifo_acc && (fwd || test) && !full;
  wire host_pop  = hs_rd && fifo_acc && (rev || test) && !empty;
  wire eng_pop   = st == S_IDLE && fwd && !empty;
  wire eng_push  = st == S_IDLE && rev && !pclk_n && !full;
  wire push = host_push || eng_push;
  wire pop  = host_pop || eng_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 3'b000;
      dir  <= 1'b0;
    end else if (ecr_wr) begin
      mode <= hs_wdata[7:5];
      dir  <= hs_wdata[4];
    end
  end

  always_ff @(posedge clk) begin
    if (push && !mode_chg) mem[wptr] <= eng_push ? pd_in : hs_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (mode_chg) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      out_q <= '0;
      scnt  <= '0;
    end else if (mode_chg) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE:
          if (eng_pop) begin
            out_q <= head;
            st    <= (mode == M_COMPAT) ? S_SETUP : S_EACK;
          end else if (eng_push) begin
            st <= S_RACK;
          end
        S_SETUP:
          if (!busy) begin
            st   <= S_STB;
            scnt <= '0;
          end
        S_STB: begin
          scnt <= scnt + 1'b1;
          if (scnt == SW'(STB_CLKS - 1)) st <= S_HOLD;
        end
        S_HOLD: if (!busy) st <= S_IDLE;
        S_EACK: if (busy) st <= S_EREL;
        S_EREL: if (!busy) st <= S_IDLE;
        S_RACK: if (pclk_n) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign stb_n   = !(st == S_STB || st == S_EACK);
  assign hack    = st == S_RACK;
  assign pd_oe   = fwd || test;
  assign pd_out  = test ? head : out_q;
  assign dma_req = (fwd && !full) || (rev && !empty);

  always_comb begin
    if (dma_ack) hs_rdata = head;
    else begin
      case (hs_addr)
        2'd0:    hs_rdata = (mode == M_CFG) ? 8'h10 : head;
        2'd1:    hs_rdata = (mode == M_CFG) ? {1'b0, irq_in, 6'b0} : 8'h00;
        2'd2:    hs_rdata = {mode, dir, 2'b00, full, empty};
        default: hs_rdata = 8'h00;
      endcase
    end
  end

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && hs_wr && fifo_acc && !pop && !ecr_wr) |=> cnt == $past(cnt));

  // R3
  test_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TEST) |-> (stb_n && !hack));

  // R6
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stb_n) && mode == M_COMPAT && !mode_chg) |=> !stb_n);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_n && !$past(stb_n)) |-> $stable(pd_out));

  // R8
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hack) |-> !$past(pclk_n));

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (empty && stb_n && !hack));
endmodule

// File: tb/tb_ecp_fifo_port.sv
module tb_ecp_fifo_port;
  logic clk = 0, rst_n = 0;
  logic hs_wr = 0, hs_rd = 0, dma_ack = 0, irq_in = 0, busy = 0, pclk_n = 1;
  logic [1:0] hs_addr = 0;
  logic [7:0] hs_wdata = 0, pd_in = 0;
  logic [7:0] hs_rdata, pd_out;
  logic dma_req, pd_oe, stb_n, hack;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  ecp_fifo_port dut (.clk, .rst_n, .hs_wr, .hs_rd, .hs_addr, .hs_wdata, .hs_rdata,
    .dma_req, .dma_ack, .irq_in, .pd_out, .pd_in, .pd_oe, .stb_n, .busy, .pclk_n, .hack);

  // row: req[23:20] op[19:18] (0 wr,1 rd chk,2 rd no chk) addr[17:16] data[15:8] exp[7:0]
  localparam int NV = 19;
  localparam logic [23:0] VEC [NV] = '{
    24'h1_6_00_01,  // R1 control reg after reset
    24'hB_2_C0_00,  // R11 select mode 110
    24'hB_6_00_C1,  // R11
    24'h3_0_A5_00,  // R3
    24'h3_0_3C_00,  // R3
    24'h3_0_7E_00,  // R3
    24'hB_6_00_C0,  // R11 not empty
    24'h2_4_00_A5,  // R2 order
    24'h2_4_00_3C,  // R2
    24'h2_4_00_7E,  // R2
    24'h2_8_00_00,  // R2 read while empty
    24'h2_0_11_00,  // R2
    24'h2_4_00_11,  // R2 pointers intact
    24'hB_6_00_C1,  // R11
    24'h4_2_E0_00,  // R4 select mode 111
    24'h4_4_00_10,  // R4
    24'h5_5_00_00,  // R5 irq low
    24'h4_0_55_00,  // R4 write ignored
    24'hB_6_00_E1   // R11 still empty
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); hs_wr = 1; hs_addr = a; hs_wdata = d;
    @(negedge clk); hs_wr = 0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); hs_rd = 1; hs_addr = a;
    #2 d = hs_rdata;
    @(negedge clk); hs_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int lo;
    idle(2);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1", {stb_n, hack, pd_oe, dma_req}, 8'h08);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19:18] == 2'd0) host_wr(VEC[i][17:16], VEC[i][15:8]);
      else begin
        host_rd(VEC[i][17:16], d);
        if (VEC[i][19:18] == 2'd1) chk($sformatf("R%0d row %0d", VEC[i][23:20], i), d, VEC[i][7:0]);
      end
    end

    // R5
    irq_in = 1;
    host_rd(2'd1, d); chk("R5", d, 8'h40);
    irq_in = 0;

    // R3 head on port, no handshake; R9 no request in test mode
    host_wr(2'd2, 8'hC0);
    host_wr(2'd0, 8'h5A);
    idle(3);
    chk("R3", {pd_oe, stb_n, hack, 5'b0}, 8'hC0);
    chk("R3", pd_out, 8'h5A);
    chk("R9", {7'b0, dma_req}, 8'h00);

    // R10 flush on mode change
    host_wr(2'd2, 8'hE0);
    host_rd(2'd2, d); chk("R10", d, 8'hE1);

    // R6 compatibility, R2 full drop, R9 request
    busy = 1;
    host_wr(2'd2, 8'h40);
    chk("R9", {7'b0, dma_req}, 8'h01);
    for (int i = 0; i < 17; i++) host_wr(2'd0, 8'(i));
    host_wr(2'd0, 8'hEE);
    host_rd(2'd2, d); chk("R2", d, 8'h42);
    chk("R9", {7'b0, dma_req}, 8'h00);
    idle(5);
    chk("R6", {7'b0, stb_n}, 8'h01);
    busy = 0;
    for (int i = 0; i < 17; i++) begin
      while (stb_n) @(negedge clk);
      chk("R6", pd_out, 8'(i));
      lo = 0;
      while (!stb_n) begin lo++; @(negedge clk); end
      chk("R6", {7'b0, lo >= 2}, 8'h01);
    end
    idle(10);
    chk("R2", {7'b0, stb_n}, 8'h01);
    host_rd(2'd2, d); chk("R2", d, 8'h41);

    // R7 ECP forward
    host_wr(2'd2, 8'h60);
    host_wr(2'd0, 8'hC3);
    host_wr(2'd0, 8'h96);
    while (stb_n) @(negedge clk);
    chk("R7", pd_out, 8'hC3);
    idle(3);
    chk("R7", {7'b0, stb_n}, 8'h00);
    busy = 1;
    while (!stb_n) @(negedge clk);
    idle(2);
    chk("R7", {7'b0, stb_n}, 8'h01);
    busy = 0;
    while (stb_n) @(negedge clk);
    chk("R7", pd_out, 8'h96);
    busy = 1;
    while (!stb_n) @(negedge clk);
    busy = 0;
    idle(2);
    host_rd(2'd2, d); chk("R7", d, 8'h61);

    // R8 ECP reverse, R9
    host_wr(2'd2, 8'h70);
    chk("R8", {7'b0, pd_oe}, 8'h00);
    chk("R9", {7'b0, dma_req}, 8'h00);
    foreach (VEC[k]) if (k < 2) begin
      pd_in = (k == 0) ? 8'h81 : 8'h42;
      pclk_n = 0;
      while (!hack) @(negedge clk);
      pclk_n = 1;
      while (hack) @(negedge clk);
    end
    chk("R9", {7'b0, dma_req}, 8'h01);
    host_rd(2'd0, d); chk("R8", d, 8'h81);
    @(negedge clk); hs_rd = 1; dma_ack = 1; hs_addr = 2'd2;
    #2 d = hs_rdata;
    @(negedge clk); hs_rd = 0; dma_ack = 0;
    chk("R8", d, 8'h42);
    host_rd(2'd2, d); chk("R8", d, 8'h71);

    // R10 handshake returns to idle
    busy = 1;
    host_wr(2'd2, 8'h40);
    host_wr(2'd0, 8'h77);
    idle(2);
    host_wr(2'd2, 8'h60);
    busy = 0;
    idle(5);
    chk("R10", {7'b0, stb_n}, 8'h01);
    host_rd(2'd2, d); chk("R10", d, 8'h61);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule